// File: doc/BRIEF.md
# Programmable Third-Order Comb Decimator

This block turns the one-bit stream of a sigma-delta modulator into 16-bit signed PCM samples. Every modulator clock, one input bit enters a chain of three integrators. Once per decimation window of D clocks, a chain of three differentiators takes the third difference of the last integrator. The result is the triple boxcar (sinc-cubed) average of the last windows of input. A two-bit select chooses D from four ratios, and not all of them are powers of two. Each ratio has its own power-of-two gain, chosen so that the DC gain stays near unity.

Normalization takes the comb output, multiplies it by the gain with a left shift, and divides it by 2^21 (128 cubed). Unity is taken as 2^15 LSB, so the arithmetic right shift is 6 bits in total. The result then saturates to 16 bits. A new ratio takes effect only at a window boundary. The first three samples after reset, and after an applied ratio change, carry a settling flag.

Top module: `sdm_sinc3_decim`

## Requirements
- R1: An input bit of 1 counts as +1 and a 0 counts as -1. Take a steady input pattern whose period P divides D and which holds k ones per period. Once settled, the output equals sat16(floor(c * D^3 * (2k - P) / P / 64)), where sat16 clamps to the range -32768..32767.
- R2: `rate_sel` encodes 00 → D=125, 01 → D=128, 10 → D=105 and 11 → D=81. Consecutive `pcm_valid` pulses are exactly D clocks apart.
- R3: The gain c is 1 for D=125 and for D=128, 2 for D=105, and 4 for D=81.
- R4: Results beyond 16 bits saturate: positive ones to 32767 and negative ones to -32768.
- R5: `pcm_valid` is a single-clock pulse, one clock after each window boundary. `pcm_out` changes only in a clock where `pcm_valid` is high.
- R6: A change of `rate_sel` is sampled only at a window boundary, so the window in progress keeps its old length. A change that is reverted before the boundary has no effect.
- R7: `pcm_settle` is high only together with `pcm_valid`. It is high on the first three samples after reset and on the first three samples at a newly applied ratio, and low on every other sample.
- R8: While `rst` is high, `pcm_out` is 0 and `pcm_valid` is 0. The first `pcm_valid` appears after the D-th rising edge that follows reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_bit | input | 1 | Modulator output bit |
| rate_sel | input | 2 | Decimation ratio select |
| pcm_out | output | 16 | Signed PCM sample |
| pcm_valid | output | 1 | One-clock strobe for a new sample |
| pcm_settle | output | 1 | Sample belongs to the settling interval |

## Verification
The window boundary is where two functions meet in one clock. A sample is emitted from the closing window, and in the same clock a pending ratio select is adopted and the settling counter is re-armed. The bench provokes this by changing `rate_sel` partway through a window. It then judges the spacing of the following strobes: one gap of the old length, then gaps of the new length. It also judges the settling flags: clear on the closing sample, set on the next three, clear on the fourth, whose value must already match the arithmetic model. A select that is changed and then restored within one window must leave both the spacing and the flags untouched.

// File: rtl/sdm_decim_pkg.sv
package sdm_decim_pkg;

  localparam int RATIO_W  = 8;
  localparam int CNT_W    = 7;
  localparam int SETTLE_N = 3;
  localparam int SETTLE_W = 2;

  typedef enum logic [1:0] {
    RATE_125 = 2'b00,
    RATE_128 = 2'b01,
    RATE_105 = 2'b10,
    RATE_81  = 2'b11
  } rate_e;

  function automatic logic [RATIO_W-1:0] ratio_of(input logic [1:0] sel);
    case (sel)
      RATE_125: ratio_of = 8'd125;
      RATE_128: ratio_of = 8'd128;
      RATE_105: ratio_of = 8'd105;
      default:  ratio_of = 8'd81;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] last_count_of(input logic [1:0] sel);
    case (sel)
      RATE_125: last_count_of = 7'd124;
      RATE_128: last_count_of = 7'd127;
      RATE_105: last_count_of = 7'd104;
      default:  last_count_of = 7'd80;
    endcase
  endfunction

  function automatic logic [1:0] gain_shift_of(input logic [1:0] sel);
    case (sel)
      RATE_105: gain_shift_of = 2'd1;
      RATE_81:  gain_shift_of = 2'd2;
      default:  gain_shift_of = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/decim_sequencer.sv
module decim_sequencer
  import sdm_decim_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          rate_sel,
  output logic                dec_tick,
  output logic                sel_change,
  output logic [1:0]          cur_sel,
  output logic [SETTLE_W-1:0] settle_cnt,
  output logic                sample_settling
);

  logic [CNT_W-1:0] phase_cnt;

  assign dec_tick        = (phase_cnt == last_count_of(cur_sel));
  assign sel_change      = dec_tick && (rate_sel != cur_sel);
  assign sample_settling = (settle_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_cnt  <= '0;
      cur_sel    <= rate_sel;
      settle_cnt <= SETTLE_W'(SETTLE_N);
    end else if (dec_tick) begin
      phase_cnt <= '0;
      cur_sel   <= rate_sel;
      if (sel_change)
        settle_cnt <= SETTLE_W'(SETTLE_N);
      else if (sample_settling)
        settle_cnt <= settle_cnt - 1'b1;
    end else begin
      phase_cnt <= phase_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/cic_integrators.sv
module cic_integrators #(
  parameter int ACC_W  = 23,
  parameter int STAGES = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bit_in,
  output logic signed [ACC_W-1:0] integ_out
);

  logic signed [ACC_W-1:0] feed  [STAGES];
  logic signed [ACC_W-1:0] stage [STAGES];

  // +1 for a one, -1 for a zero
  assign feed[0] = {{(ACC_W-1){~bit_in}}, 1'b1};

  for (genvar s = 0; s < STAGES; s++) begin : g_int
    logic signed [ACC_W-1:0] acc_q;
    always_ff @(posedge clk) begin
      if (rst) acc_q <= '0;
      else     acc_q <= acc_q + feed[s];
    end
    assign stage[s] = acc_q;
    if (s + 1 < STAGES) begin : g_link
      assign feed[s+1] = acc_q;
    end
  end

  assign integ_out = stage[STAGES-1];

endmodule

// File: rtl/cic_combs.sv
module cic_combs #(
  parameter int ACC_W  = 23,
  parameter int STAGES = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [ACC_W-1:0] comb_in,
  output logic signed [ACC_W-1:0] comb_out
);

  logic signed [ACC_W-1:0] diff [STAGES+1];

  assign diff[0] = comb_in;

  for (genvar s = 0; s < STAGES; s++) begin : g_comb
    logic signed [ACC_W-1:0] dly_q;
    always_ff @(posedge clk) begin
      if (rst)     dly_q <= '0;
      else if (en) dly_q <= diff[s];
    end
    assign diff[s+1] = diff[s] - dly_q;
  end

  assign comb_out = diff[STAGES];

endmodule

// File: rtl/pcm_normalizer.sv
module pcm_normalizer #(
  parameter int ACC_W      = 23,
  parameter int PCM_W      = 16,
  parameter int NORM_SHIFT = 21
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic                    settling,
  input  logic [1:0]              gain_shift,
  input  logic signed [ACC_W-1:0] comb_val,
  output logic signed [PCM_W-1:0] pcm_out,
  output logic                    pcm_valid,
  output logic                    pcm_settle
);

  localparam int WIDE_W = ACC_W + 3;
  localparam int DROP   = NORM_SHIFT - (PCM_W - 1);

  function automatic logic signed [PCM_W-1:0] scale_sample(
    input logic signed [ACC_W-1:0] v,
    input logic [1:0]              sh
  );
    logic signed [WIDE_W-1:0] wide;
    logic signed [WIDE_W-1:0] q;
    logic [WIDE_W-PCM_W:0]    hi;
    wide = {{3{v[ACC_W-1]}}, v};
    wide = wide <<< sh;
    q    = wide >>> DROP;
    hi   = q[WIDE_W-1:PCM_W-1];
    if (hi == '0 || hi == '1)
      scale_sample = q[PCM_W-1:0];
    else if (q[WIDE_W-1])
      scale_sample = {1'b1, {(PCM_W-1){1'b0}}};
    else
      scale_sample = {1'b0, {(PCM_W-1){1'b1}}};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      pcm_out    <= '0;
      pcm_valid  <= 1'b0;
      pcm_settle <= 1'b0;
    end else begin
      pcm_valid  <= load;
      pcm_settle <= load && settling;
      if (load) pcm_out <= scale_sample(comb_val, gain_shift);
    end
  end

endmodule

// File: rtl/sdm_sinc3_decim.sv
module sdm_sinc3_decim
  import sdm_decim_pkg::*;
#(
  parameter int ACC_W      = 23,
  parameter int STAGES     = 3,
  parameter int PCM_W      = 16,
  parameter int NORM_SHIFT = 21
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    mod_bit,
  input  logic [1:0]              rate_sel,
  output logic signed [PCM_W-1:0] pcm_out,
  output logic                    pcm_valid,
  output logic                    pcm_settle
);

  logic                    dec_tick;
  logic                    sel_change;
  logic [1:0]              cur_sel;
  logic [SETTLE_W-1:0]     settle_cnt;
  logic                    sample_settling;
  logic signed [ACC_W-1:0] integ_val;
  logic signed [ACC_W-1:0] comb_val;
  logic [1:0]              gain_sh;

  assign gain_sh = gain_shift_of(cur_sel);

  decim_sequencer u_seq (
    .clk(clk), .rst(rst), .rate_sel(rate_sel),
    .dec_tick(dec_tick), .sel_change(sel_change), .cur_sel(cur_sel),
    .settle_cnt(settle_cnt), .sample_settling(sample_settling)
  );

  cic_integrators #(.ACC_W(ACC_W), .STAGES(STAGES)) u_int (
    .clk(clk), .rst(rst), .bit_in(mod_bit), .integ_out(integ_val)
  );

  cic_combs #(.ACC_W(ACC_W), .STAGES(STAGES)) u_comb (
    .clk(clk), .rst(rst), .en(dec_tick),
    .comb_in(integ_val), .comb_out(comb_val)
  );

  pcm_normalizer #(.ACC_W(ACC_W), .PCM_W(PCM_W), .NORM_SHIFT(NORM_SHIFT)) u_norm (
    .clk(clk), .rst(rst), .load(dec_tick), .settling(sample_settling),
    .gain_shift(gain_sh), .comb_val(comb_val),
    .pcm_out(pcm_out), .pcm_valid(pcm_valid), .pcm_settle(pcm_settle)
  );

endmodule

module sdm_sinc3_decim_chk
  import sdm_decim_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic [1:0]          rate_sel,
  input logic                dec_tick,
  input logic [1:0]          cur_sel,
  input logic [SETTLE_W-1:0] settle_cnt,
  input logic                pcm_valid,
  input logic                pcm_settle,
  input logic [15:0]         pcm_out
);

  logic [RATIO_W-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (rst || dec_tick) gap_cnt <= '0;
    else                 gap_cnt <= gap_cnt + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    dec_tick |-> (RATIO_W'(gap_cnt + 1'b1) == ratio_of(cur_sel))); // R2
  AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    dec_tick |=> pcm_valid); // R5
  AST_VALID_ONLY_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    !dec_tick |=> !pcm_valid); // R5
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
    !pcm_valid |-> $stable(pcm_out)); // R5
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (rst)
    !dec_tick |=> $stable(cur_sel)); // R6
  AST_SETTLE_ARMED: assert property (@(posedge clk) disable iff (rst)
    (dec_tick && (rate_sel != cur_sel)) |=> (settle_cnt == SETTLE_W'(SETTLE_N))); // R7
  AST_SETTLE_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    pcm_settle |-> pcm_valid); // R7

endmodule

bind sdm_sinc3_decim sdm_sinc3_decim_chk u_chk (
  .clk(clk), .rst(rst), .rate_sel(rate_sel), .dec_tick(dec_tick),
  .cur_sel(cur_sel), .settle_cnt(settle_cnt), .pcm_valid(pcm_valid),
  .pcm_settle(pcm_settle), .pcm_out(pcm_out)
);

// File: tb/sim_sdm_sinc3_decim.sv
`timescale 1ns/1ps
module sim_sdm_sinc3_decim;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              mod_bit = 1'b0;
  logic [1:0]        rate_sel = 2'b01;
  logic signed [15:0] pcm_out;
  logic              pcm_valid;
  logic              pcm_settle;

  int     n_checks = 0;
  int     n_fails  = 0;
  longint cyc = 0;
  longint last_valid = 0;
  int     pat_p = 1;
  int     pat_k = 1;
  int     ph = 0;

  sdm_sinc3_decim u0 (
    .clk(clk), .rst(rst), .mod_bit(mod_bit), .rate_sel(rate_sel),
    .pcm_out(pcm_out), .pcm_valid(pcm_valid), .pcm_settle(pcm_settle)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    mod_bit <= (ph < pat_k);
    ph      <= (ph + 1 >= pat_p) ? 0 : ph + 1;
  end

  function automatic longint b_ratio(int sel);
    case (sel)
      0: return 125;
      1: return 128;
      2: return 105;
      default: return 81;
    endcase
  endfunction

  function automatic longint b_gain(int sel);
    case (sel)
      2: return 2;
      3: return 4;
      default: return 1;
    endcase
  endfunction

  function automatic longint b_raw(int sel, int p, int k);
    longint d = b_ratio(sel);
    return (b_gain(sel) * d * d * d / p * (2 * k - p)) >>> 6;
  endfunction

  function automatic longint b_expect(int sel, int p, int k);
    longint v = b_raw(sel, p, k);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_valid(output longint gap);
    do begin
      @(posedge clk);
      #1;
    end while (!pcm_valid);
    gap = cyc - last_valid;
    last_valid = cyc;
  endtask

  task automatic run_case(int sel, int p, int k);
    longint gap;
    longint e;
    string  req;
    rate_sel = sel[1:0];
    pat_p = p;
    pat_k = k;
    repeat (5) wait_valid(gap);
    e = b_expect(sel, p, k);
    if (e != b_raw(sel, p, k)) req = "R4";
    else if (b_gain(sel) > 1)  req = "R3";
    else                       req = "R1";
    for (int i = 0; i < 2; i++) begin
      wait_valid(gap);
      check(pcm_out == e, req, "settled sample", pcm_out, e);
      check(gap == b_ratio(sel), "R2", "strobe spacing", gap, b_ratio(sel));
      check(pcm_settle == 1'b0, "R7", "settle flag", pcm_settle, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    longint gap;
    int n;
    // R8: reset state and first strobe position
    repeat (3) @(posedge clk);
    #1;
    check(pcm_out == 0, "R8", "pcm_out in reset", pcm_out, 0);
    check(pcm_valid == 0, "R8", "pcm_valid in reset", pcm_valid, 0);
    @(negedge clk);
    rst = 1'b0;
    n = 0;
    do begin
      @(posedge clk);
      #1;
      n++;
    end while (!pcm_valid && n < 1000);
    last_valid = cyc;
    check(n == 128, "R8", "first strobe edge", n, 128);
    check(pcm_settle == 1'b1, "R7", "settle after reset #1", pcm_settle, 1);
    for (int i = 2; i <= 3; i++) begin
      wait_valid(gap);
      check(pcm_settle == 1'b1, "R7", "settle after reset", pcm_settle, 1);
    end
    wait_valid(gap);
    check(pcm_settle == 1'b0, "R7", "settle clear after three", pcm_settle, 0);
    @(posedge clk);
    #1;
    check(pcm_valid == 1'b0, "R5", "strobe width", pcm_valid, 0);

    // R1 R2 R3 R4: sweep of ratios and periodic densities
    for (int sel = 0; sel < 4; sel++) begin
      for (int p = 1; p <= 9; p++) begin
        if (b_ratio(sel) % p == 0) begin
          for (int k = 0; k <= p; k++) run_case(sel, p, k);
        end
      end
    end

    // R6 R7: ratio change inside a window (81 -> 128)
    wait_valid(gap);
    repeat (10) @(posedge clk);
    #1;
    rate_sel = 2'b01;
    wait_valid(gap);
    check(gap == 81, "R6", "window in progress keeps old length", gap, 81);
    check(pcm_settle == 1'b0, "R7", "closing sample not settling", pcm_settle, 0);
    for (int i = 0; i < 3; i++) begin
      wait_valid(gap);
      check(gap == 128, "R6", "new window length", gap, 128);
      check(pcm_settle == 1'b1, "R7", "settle after change", pcm_settle, 1);
    end
    wait_valid(gap);
    check(pcm_settle == 1'b0, "R7", "settle clear after change", pcm_settle, 0);
    check(pcm_out == b_expect(1, pat_p, pat_k), "R7", "first settled value",
          pcm_out, b_expect(1, pat_p, pat_k));

    // R6: select changed and restored inside one window is ignored
    repeat (10) @(posedge clk);
    #1;
    rate_sel = 2'b10;
    repeat (20) @(posedge clk);
    #1;
    rate_sel = 2'b01;
    for (int i = 0; i < 2; i++) begin
      wait_valid(gap);
      check(gap == 128, "R6", "reverted select spacing", gap, 128);
      check(pcm_settle == 1'b0, "R6", "reverted select no settle", pcm_settle, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule